// File: doc/BRIEF.md
# Compare-Match Interrupt Controller

This block sits beside a pair of charge/discharge accumulators in a battery-monitoring subsystem. It holds a 32-bit threshold that the host loads in two 16-bit halves through decoded write-word commands. It compares that threshold for equality against whichever live counter the host selected. It also keeps four sticky event flags: discharge overcurrent, charge overcurrent, threshold match and current-direction reversal. These flags drive one active-low interrupt line, suitable for an open-drain pad.

While the low half of the threshold is being written, the match source is disarmed, so a half-written threshold can never raise a false match. Loading the upper half re-arms it. Two things bring the state out: a 16-bit status word, and a one-byte reply to an alert-response query. That reply releases the interrupt line without erasing the flags. The serial framing and the counters themselves live elsewhere.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset all four sticky flags read 0, `irq_n` is 1, the threshold is 0 and the match source is disarmed, so no match is flagged even when the counter equals 0 and `cfg_cmp_en` is 1.
- R2: A `wr_start` with command 0x00 disarms the match source at that clock edge. A `wr_commit` with command 0x00 stores `wr_data[7:0]` in threshold byte 0 and `wr_data[15:8]` in byte 1. While disarmed, equality raises no flag.
- R3: A `wr_commit` with command 0x01 stores `wr_data[7:0]` in threshold byte 2 and `wr_data[15:8]` in byte 3, and arms the match source at that edge. A match can then be flagged one clock later.
- R4: While armed and `cfg_cmp_en` is 1, the clock edge after equality begins sets status bit 5 and drives `irq_n` low. An equality that persists sets the flag only once: after a clear it does not set again until equality is lost and regained.
- R5: Any change of `chg_dir` sets status bit 1 at the next edge. Further reversals leave it set. The reversal pulls `irq_n` low only when `cfg_dir_irq_en` is 1.
- R6: `oc_dis_evt` sets status bit 7 and `oc_chg_evt` sets status bit 6, each at the next edge. Each also drives `irq_n` low, whatever the configuration inputs are.
- R7: A `clr_irq` pulse clears all four flags and releases `irq_n` at the next edge. While `soft_shdn` is 1, the flags and interrupt are held clear. Both take priority over any event arriving in the same cycle.
- R8: An `ara_hit` while `irq_n` is low makes `ara_vld` 1 with `ara_data` = 0x8F for one cycle after the edge, and releases `irq_n`; the flags stay set. An `ara_hit` while `irq_n` is high gives no reply.
- R9: The status word reads as follows: bits 15..8 and bit 0 are 1; bit 7 is discharge overcurrent; bit 6 is charge overcurrent; bit 5 is match; bit 4 is `cfg_cnt_sel`; bit 3 is `soft_shdn`; bit 2 is `chg_dir` (1 = charging); bit 1 is reversal.
- R10: A `wr_commit` with any command other than 0x00 or 0x01 leaves the threshold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 32 | Value of the selected live counter |
| chg_dir | input | 1 | Current direction, 1 = charging |
| oc_dis_evt | input | 1 | Discharge overcurrent comparator event |
| oc_chg_evt | input | 1 | Charge overcurrent comparator event |
| wr_start | input | 1 | Write-word command byte accepted; `wr_cmd` valid |
| wr_commit | input | 1 | Write-word data complete; `wr_cmd` and `wr_data` valid |
| wr_cmd | input | 8 | Decoded command code |
| wr_data | input | 16 | Write-word data, low byte in [7:0] |
| cfg_cmp_en | input | 1 | Compare function enable |
| cfg_dir_irq_en | input | 1 | Reversal interrupt enable |
| cfg_cnt_sel | input | 1 | Counter-select bit, mirrored in status |
| clr_irq | input | 1 | Clear-interrupt strobe |
| soft_shdn | input | 1 | Soft-shutdown state |
| ara_hit | input | 1 | Alert-response address recognised |
| irq_n | output | 1 | Active-low interrupt |
| status_word | output | 16 | Status word |
| ara_vld | output | 1 | Alert-response reply valid |
| ara_data | output | 8 | Alert-response reply byte |

## Verification
The bench targets the split threshold write. It puts a counter equal to the half-written threshold while the source is disarmed; a design that failed to disarm at the command byte would flag a match there. It then checks the exact cycle the upper-half commit re-arms, catching a design that arms late or flags early. A persistent equality is held across a clear, which shows up a level-sensitive match that re-fires at once. The bench also checks that a reversal with its enable low leaves the line high, that an alert reply keeps the flags, and that shutdown suppresses a coincident overcurrent, where a wrong priority would leave a stale flag.

// File: rtl/cmp_irq_pkg.sv
// Package: shared widths, command codes and status bit positions for the
// compare-match interrupt controller.
package cmp_irq_pkg;
    localparam int CNT_W  = 32;
    localparam int HALF_W = CNT_W / 2;

    localparam logic [7:0] CMD_THR_LO = 8'h00;
    localparam logic [7:0] CMD_THR_HI = 8'h01;
    localparam logic [7:0] ARA_REPLY  = 8'h8F;

    // Sticky flag vector order used inside the status block
    localparam int FLG_DIR = 0;
    localparam int FLG_CMP = 1;
    localparam int FLG_OCC = 2;
    localparam int FLG_OCD = 3;
    localparam int N_FLG   = 4;
endpackage

// File: rtl/cmp_thresh_reg.sv
// Module: threshold register with write-time disarm and edge-qualified match.
// Holds the threshold in two halves written by separate commands. Disarms on
// the low-half command byte, arms on the high-half commit. Emits a one-cycle
// cmp_evt when qualified equality begins.
// Assumes wr_start and wr_commit are single-cycle strobes from a decoder.
module cmp_thresh_reg
    import cmp_irq_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   cnt_val,
    input  logic           wr_start,
    input  logic           wr_commit,
    input  logic [7:0]     wr_cmd,
    input  logic [W/2-1:0] wr_data,
    input  logic           cfg_cmp_en,
    output logic           cmp_evt
);
    localparam int HW = W / 2;

    logic [W-1:0] thr_q;
    logic         armed_q;
    logic         qual_prev_q;
    logic         qual;

    // One storage process per threshold half, selected by its command code
    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam logic [7:0] MY_CMD = CMD_THR_LO + 8'(h);
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr_q[h*HW +: HW] <= '0;
            else if (wr_commit && wr_cmd == MY_CMD)
                thr_q[h*HW +: HW] <= wr_data;
        end
    end

    // Arm state: cleared by reset and low-half command byte, set by high-half commit
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (wr_start && wr_cmd == CMD_THR_LO)
            armed_q <= 1'b0;
        else if (wr_commit && wr_cmd == CMD_THR_HI)
            armed_q <= 1'b1;
    end

    // Qualified equality and its rising edge
    always_comb begin
        qual    = armed_q && cfg_cmp_en && (cnt_val == thr_q);
        cmp_evt = qual && !qual_prev_q;
    end

    // Previous qualified-equality sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) qual_prev_q <= 1'b0;
        else        qual_prev_q <= qual;
    end

    a_r2_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && wr_cmd == CMD_THR_LO) |=> !armed_q);
    a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && wr_cmd == CMD_THR_HI && !wr_start) |=> armed_q);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(thr_q));
    a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> !cmp_evt);
endmodule

// File: rtl/cmp_status_ctrl.sv
// Module: sticky flags, interrupt latch, status word and alert reply.
// Sets flags from events, clears them on clr_irq and holds them clear during
// soft shutdown. Releases only the interrupt on an acknowledged alert query.
// Assumes event inputs are already synchronous to clk.
module cmp_status_ctrl
    import cmp_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmp_evt,
    input  logic        chg_dir,
    input  logic        oc_dis_evt,
    input  logic        oc_chg_evt,
    input  logic        cfg_dir_irq_en,
    input  logic        cfg_cnt_sel,
    input  logic        clr_irq,
    input  logic        soft_shdn,
    input  logic        ara_hit,
    output logic        irq_n,
    output logic [15:0] status_word,
    output logic        ara_vld,
    output logic [7:0]  ara_data
);
    logic [N_FLG-1:0] flg_q;
    logic [N_FLG-1:0] flg_set;
    logic             dir_prev_q;
    logic             dir_evt;
    logic             irq_q;
    logic             irq_set;
    logic             wipe;
    logic             ara_q;

    // Event vector and interrupt request
    always_comb begin
        dir_evt          = chg_dir ^ dir_prev_q;
        flg_set          = '0;
        flg_set[FLG_DIR] = dir_evt;
        flg_set[FLG_CMP] = cmp_evt;
        flg_set[FLG_OCC] = oc_chg_evt;
        flg_set[FLG_OCD] = oc_dis_evt;
        irq_set          = oc_dis_evt || oc_chg_evt || cmp_evt || (dir_evt && cfg_dir_irq_en);
        wipe             = clr_irq || soft_shdn;
    end

    // Direction history, seeded from the live input during reset
    always_ff @(posedge clk) begin
        dir_prev_q <= chg_dir;
    end

    // Sticky flags, one bit per source
    for (genvar i = 0; i < N_FLG; i++) begin : g_flg
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)  flg_q[i] <= 1'b0;
            else if (flg_set[i]) flg_q[i] <= 1'b1;
        end
    end

    // Interrupt latch: wipe beats set, set beats alert release
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)        irq_q <= 1'b0;
        else if (irq_set)          irq_q <= 1'b1;
        else if (ara_hit && irq_q) irq_q <= 1'b0;
    end

    // Alert reply strobe, only when this block was alerting
    always_ff @(posedge clk) begin
        if (!rst_n) ara_q <= 1'b0;
        else        ara_q <= ara_hit && irq_q;
    end

    // Output assembly
    always_comb begin
        irq_n       = !irq_q;
        ara_vld     = ara_q;
        ara_data    = ara_q ? ARA_REPLY : 8'h00;
        status_word = {8'hFF, flg_q[FLG_OCD], flg_q[FLG_OCC], flg_q[FLG_CMP],
                       cfg_cnt_sel, soft_shdn, chg_dir, flg_q[FLG_DIR], 1'b1};
    end

    a_r7_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_irq || soft_shdn) |=> (status_word[7:5] == 3'b000 && !status_word[1] && irq_n));
    a_r6_ocd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_dis_evt && !clr_irq && !soft_shdn) |=> (status_word[7] && !irq_n));
    a_r8_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_hit && !irq_n) |=> (ara_vld && ara_data == ARA_REPLY));
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[1] && !clr_irq && !soft_shdn) |=> status_word[1]);
endmodule

// File: rtl/cmp_irq_ctrl.sv
// Module: top of the compare-match interrupt controller.
// Joins the threshold/match unit and the flag/interrupt unit.
// Assumes all inputs are synchronous to clk; irq_n feeds an open-drain pad.
module cmp_irq_ctrl
    import cmp_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cnt_val,
    input  logic        chg_dir,
    input  logic        oc_dis_evt,
    input  logic        oc_chg_evt,
    input  logic        wr_start,
    input  logic        wr_commit,
    input  logic [7:0]  wr_cmd,
    input  logic [15:0] wr_data,
    input  logic        cfg_cmp_en,
    input  logic        cfg_dir_irq_en,
    input  logic        cfg_cnt_sel,
    input  logic        clr_irq,
    input  logic        soft_shdn,
    input  logic        ara_hit,
    output logic        irq_n,
    output logic [15:0] status_word,
    output logic        ara_vld,
    output logic [7:0]  ara_data
);
    logic cmp_evt;

    cmp_thresh_reg #(.W(CNT_W)) u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_val    (cnt_val),
        .wr_start   (wr_start),
        .wr_commit  (wr_commit),
        .wr_cmd     (wr_cmd),
        .wr_data    (wr_data),
        .cfg_cmp_en (cfg_cmp_en),
        .cmp_evt    (cmp_evt)
    );

    cmp_status_ctrl u_sts (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmp_evt        (cmp_evt),
        .chg_dir        (chg_dir),
        .oc_dis_evt     (oc_dis_evt),
        .oc_chg_evt     (oc_chg_evt),
        .cfg_dir_irq_en (cfg_dir_irq_en),
        .cfg_cnt_sel    (cfg_cnt_sel),
        .clr_irq        (clr_irq),
        .soft_shdn      (soft_shdn),
        .ara_hit        (ara_hit),
        .irq_n          (irq_n),
        .status_word    (status_word),
        .ara_vld        (ara_vld),
        .ara_data       (ara_data)
    );
endmodule

// File: tb/cmp_irq_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module cmp_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cnt_val;
    logic        chg_dir, oc_dis_evt, oc_chg_evt;
    logic        wr_start, wr_commit;
    logic [7:0]  wr_cmd;
    logic [15:0] wr_data;
    logic        cfg_cmp_en, cfg_dir_irq_en, cfg_cnt_sel;
    logic        clr_irq, soft_shdn, ara_hit;
    logic        irq_n, ara_vld;
    logic [15:0] status_word;
    logic [7:0]  ara_data;

    int n_run = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cmp_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .chg_dir(chg_dir),
        .oc_dis_evt(oc_dis_evt), .oc_chg_evt(oc_chg_evt),
        .wr_start(wr_start), .wr_commit(wr_commit), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .cfg_cmp_en(cfg_cmp_en), .cfg_dir_irq_en(cfg_dir_irq_en), .cfg_cnt_sel(cfg_cnt_sel),
        .clr_irq(clr_irq), .soft_shdn(soft_shdn), .ara_hit(ara_hit),
        .irq_n(irq_n), .status_word(status_word), .ara_vld(ara_vld), .ara_data(ara_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cmd(input logic [7:0] c);
        wr_start = 1'b1; wr_cmd = c; cyc(1); wr_start = 1'b0;
    endtask

    task automatic commit_cmd(input logic [7:0] c, input logic [15:0] d);
        wr_commit = 1'b1; wr_cmd = c; wr_data = d; cyc(1); wr_commit = 1'b0;
    endtask

    task automatic do_clr;
        clr_irq = 1'b1; cyc(1); clr_irq = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(1);
        chk("R1 status after reset", 32'(status_word), 32'h0000FF01);
        chk("R1 irq_n after reset", 32'(irq_n), 32'd1);
        cfg_cmp_en = 1'b1; cnt_val = 32'd1; cyc(1); cnt_val = 32'd0; cyc(3);
        chk("R1 disarmed at reset, no match on 0", 32'(status_word[5]), 32'd0);
        chk("R9 layout ones and fields", 32'(status_word), 32'h0000FF01);
    endtask

    task automatic t_compare;
        start_cmd(8'h00); commit_cmd(8'h00, 16'h5678);
        start_cmd(8'h01); commit_cmd(8'h01, 16'h1234);
        cnt_val = 32'h12345677; cyc(2);
        chk("R4 no match on unequal value", 32'(status_word[5]), 32'd0);
        cnt_val = 32'h12345678; cyc(1);
        chk("R4 match flag", 32'(status_word[5]), 32'd1);
        chk("R4 match drives irq", 32'(irq_n), 32'd0);
        do_clr; cyc(3);
        chk("R4 persistent equality does not refire", 32'(status_word[5]), 32'd0);
        chk("R7 clr releases irq", 32'(irq_n), 32'd1);
    endtask

    task automatic t_mask;
        start_cmd(8'h00);
        commit_cmd(8'h00, 16'h9999);
        cnt_val = 32'h12349999; cyc(3);
        chk("R2 no match while disarmed", 32'(status_word[5]), 32'd0);
        chk("R2 irq idle while disarmed", 32'(irq_n), 32'd1);
        commit_cmd(8'h01, 16'h1234);
        chk("R3 no flag at arming edge", 32'(status_word[5]), 32'd0);
        cyc(1);
        chk("R3 flag one cycle after arming", 32'(status_word[5]), 32'd1);
        do_clr;
    endtask

    task automatic t_other_cmd;
        cnt_val = 32'd0; cyc(1);
        commit_cmd(8'h04, 16'hFFFF);
        cnt_val = 32'h1234FFFF; cyc(2);
        chk("R10 other command did not load", 32'(status_word[5]), 32'd0);
        cnt_val = 32'h12349999; cyc(1);
        chk("R10 threshold retained", 32'(status_word[5]), 32'd1);
        do_clr; cnt_val = 32'd0; cyc(1);
    endtask

    task automatic t_dir;
        cfg_dir_irq_en = 1'b0; chg_dir = 1'b1; cyc(1);
        chk("R5 reversal sets bit1", 32'(status_word[1]), 32'd1);
        chk("R5 no irq without enable", 32'(irq_n), 32'd1);
        chk("R9 charging bit2", 32'(status_word[2]), 32'd1);
        chg_dir = 1'b0; cyc(2);
        chk("R5 bit1 stays on second reversal", 32'(status_word[1]), 32'd1);
        do_clr;
        cfg_dir_irq_en = 1'b1; chg_dir = 1'b1; cyc(1);
        chk("R5 irq with enable", 32'(irq_n), 32'd0);
        do_clr; cfg_dir_irq_en = 1'b0;
    endtask

    task automatic t_oc;
        cfg_cmp_en = 1'b0;
        oc_dis_evt = 1'b1; cyc(1); oc_dis_evt = 1'b0;
        chk("R6 discharge overcurrent bit7", 32'(status_word[7]), 32'd1);
        chk("R6 discharge overcurrent irq", 32'(irq_n), 32'd0);
        do_clr;
        oc_chg_evt = 1'b1; cyc(1); oc_chg_evt = 1'b0;
        chk("R6 charge overcurrent bit6", 32'(status_word[7:6]), 32'd1);
        chk("R6 charge overcurrent irq", 32'(irq_n), 32'd0);
        cfg_cmp_en = 1'b1;
    endtask

    task automatic t_shdn;
        soft_shdn = 1'b1; cyc(1);
        chk("R7 shutdown clears flags", 32'(status_word), 32'h0000FF0D);
        chk("R7 shutdown releases irq", 32'(irq_n), 32'd1);
        oc_dis_evt = 1'b1; cyc(1); oc_dis_evt = 1'b0;
        chk("R7 event suppressed in shutdown", 32'(status_word[7]), 32'd0);
        soft_shdn = 1'b0; cyc(1);
    endtask

    task automatic t_ara;
        cfg_cnt_sel = 1'b1;
        oc_chg_evt = 1'b1; cyc(1); oc_chg_evt = 1'b0;
        ara_hit = 1'b1; cyc(1); ara_hit = 1'b0;
        chk("R8 reply valid", 32'(ara_vld), 32'd1);
        chk("R8 reply byte", 32'(ara_data), 32'h8F);
        chk("R8 irq released", 32'(irq_n), 32'd1);
        chk("R9 flags kept and select mirrored", 32'(status_word), 32'h0000FF55);
        ara_hit = 1'b1; cyc(1); ara_hit = 1'b0;
        chk("R8 no reply when idle", 32'(ara_vld), 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; cnt_val = '0; chg_dir = 1'b0; oc_dis_evt = 1'b0; oc_chg_evt = 1'b0;
        wr_start = 1'b0; wr_commit = 1'b0; wr_cmd = '0; wr_data = '0;
        cfg_cmp_en = 1'b0; cfg_dir_irq_en = 1'b0; cfg_cnt_sel = 1'b0;
        clr_irq = 1'b0; soft_shdn = 1'b0; ara_hit = 1'b0;
        t_reset;
        t_compare;
        t_mask;
        t_other_cmd;
        t_dir;
        t_oc;
        t_shdn;
        t_ara;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule